// File: doc/BRIEF.md
# Interleaved Multi-Bank Vector Memory

This block holds vector operands in eight word-interleaved banks and moves whole vectors in or out of them. A vector access is described by a start word address, a word stride and an element count. The sequencer produces one element address per cycle: the low three bits of the word address pick the bank and the upper bits pick the row inside that bank. A bank that has just taken an access stays occupied for six cycles. Spreading successive elements over different banks lets those occupied periods overlap, so a unit-stride stream still moves one element per cycle.

Each bank has a small down-counter that shows when it is occupied. If the bank wanted by the next element is still occupied, the sequencer holds that element and everything behind it until the bank is free. Elements are never reordered. When a bank's occupied period runs out it reports the element index it served and the word it read, or the word it wrote. A one-cycle completion pulse follows the response of the final element.

For a store, the block shows the index of the element it is about to issue on `wr_idx`. The client drives the matching word on `wr_data` in the same cycle, as combinational data.

Top module: `vmem_banked`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `rsp_valid` and `done` are low.
- R2: Element i uses word address (base + i*stride) mod 256. The bank is address bits [2:0] and the row is bits [7:3]. Addresses wrap past 255 back to 0.
- R3: A bank that accepts an element in cycle c accepts nothing more before cycle c+7. Two accesses to the same bank are therefore at least 7 cycles apart.
- R4: Elements issue strictly in index order, at most one per cycle. Element 0 issues in the first cycle after `start` is sampled. Each later element issues in the first cycle that is both after the previous issue and one in which its bank is free. A stalled element also holds back every element behind it.
- R5: With stride 1, or with any stride whose next eight addresses fall in eight different banks, the block issues one element every cycle with no stall.
- R6: The response for an element issued in cycle c appears in cycle c+6. In that cycle `rsp_valid` is high for exactly that one cycle, `rsp_idx` carries the element index, and for a load `rsp_data` carries the word stored at that address.
- R7: A store writes the `wr_data` value presented while `wr_idx` equals the element index. Its response echoes that word on `rsp_data`.
- R8: `done` pulses for one cycle, in the cycle after the last element's response. `busy` is low from that same cycle onward.
- R9: A `start` pulse while `busy` is high is ignored. The running vector keeps its addresses, its element count, its direction and its timing.
- R10: A vector length of 0 produces no response. `done` pulses in the cycle after `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector access (sampled while idle) |
| is_write | input | 1 | 1 = store vector, 0 = load vector |
| base | input | 8 | Word address of element 0 |
| stride | input | 8 | Word distance between consecutive elements |
| vlen | input | 7 | Number of elements |
| wr_idx | output | 7 | Index of the element offered for issue this cycle |
| wr_data | input | 32 | Store data for the element at `wr_idx` |
| busy | output | 1 | A vector access is in progress |
| rsp_valid | output | 1 | An element completes this cycle |
| rsp_idx | output | 7 | Index of the completing element |
| rsp_data | output | 32 | Loaded word, or echoed store word |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
Unit-stride stores and loads show that bank overlap sustains one element per cycle, including the return to bank 0 at element 8. A stride of 8 puts every element in a single bank, so issue slows to one element per seven cycles. A stride of 2 sweeps only four banks and stalls element 4, while a stride of 3 visits all eight banks and must never stall. Together these three strides separate a correct busy check from one that is off by a cycle or that lets later elements bypass a stalled one. A window that runs past address 255, a zero-length vector and a `start` pulse in mid-vector cover the wrap-around, the empty case and the ignore rule.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  // word address of element idx, before truncation to the address width
  function automatic logic [31:0] elem_word(input logic [31:0] base_w,
                                            input logic [31:0] stride_w,
                                            input logic [31:0] idx);
    return base_w + idx * stride_w;
  endfunction

  // bank index: low bits of the word address
  function automatic logic [31:0] bank_of(input logic [31:0] word, input int bank_bits);
    return word & ((32'd1 << bank_bits) - 32'd1);
  endfunction

  // row inside a bank: remaining upper bits
  function automatic logic [31:0] row_of(input logic [31:0] word, input int bank_bits);
    return word >> bank_bits;
  endfunction

endpackage

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int DATA_W   = 32,
  parameter int ROW_W    = 5,
  parameter int LEN_W    = 7,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_we,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [LEN_W-1:0]  acc_idx,
  output logic              free,
  output logic              fin,
  output logic [LEN_W-1:0]  fin_idx,
  output logic [DATA_W-1:0] fin_data
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam int DEPTH = 1 << ROW_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  tag_q;

  // occupied-period counter: loaded on accept, counts down to zero
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (acc)         cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // storage array and the per-bank result holding register
  always_ff @(posedge clk) begin
    if (acc) begin
      tag_q <= acc_idx;
      if (acc_we) begin
        mem[acc_row] <= acc_wdata;
        data_q       <= acc_wdata;
      end else begin
        data_q       <= mem[acc_row];
      end
    end
  end

  assign free     = (cnt_q == '0);
  assign fin      = (cnt_q == CNT_W'(1));
  assign fin_idx  = tag_q;
  assign fin_data = data_q;

  AST_BANK_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/vmem_issue.sv
module vmem_issue #(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 7,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  input  logic [NBANK-1:0]  bank_free,
  input  logic              fin_any,
  output logic [NBANK-1:0]  acc_vec,
  output logic [ROW_W-1:0]  acc_row,
  output logic [LEN_W-1:0]  acc_idx,
  output logic              acc_we,
  output logic              busy,
  output logic              done
);
  import vmem_pkg::*;

  logic              active_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  vlen_q, iss_cnt_q, cmp_cnt_q;

  logic [BANK_W-1:0] cur_bank;
  logic              all_issued, issue_fire, last_fin;

  assign cur_bank   = BANK_W'(bank_of(32'(addr_q), BANK_W));
  assign acc_row    = ROW_W'(row_of(32'(addr_q), BANK_W));
  assign all_issued = (iss_cnt_q == vlen_q);
  assign issue_fire = active_q && !all_issued && bank_free[cur_bank];
  assign last_fin   = active_q && fin_any && (LEN_W'(cmp_cnt_q + 1'b1) == vlen_q);

  assign acc_vec = issue_fire ? (NBANK'(1) << cur_bank) : '0;
  assign acc_idx = iss_cnt_q;
  assign acc_we  = we_q;
  assign busy    = active_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      stride_q  <= '0;
      vlen_q    <= '0;
      iss_cnt_q <= '0;
      cmp_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q && start) begin
        we_q      <= is_write;
        addr_q    <= base;
        stride_q  <= stride;
        vlen_q    <= vlen;
        iss_cnt_q <= '0;
        cmp_cnt_q <= '0;
        if (vlen == '0) done_q   <= 1'b1;
        else            active_q <= 1'b1;
      end else if (active_q) begin
        if (issue_fire) begin
          iss_cnt_q <= iss_cnt_q + 1'b1;
          addr_q    <= ADDR_W'(elem_word(32'(addr_q), 32'(stride_q), 32'd1));
        end
        if (fin_any) cmp_cnt_q <= cmp_cnt_q + 1'b1;
        if (last_fin) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  AST_START_IGNORED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start) |=> ($stable(vlen_q) && $stable(stride_q) && $stable(we_q))); // R9
  AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (all_issued && (cmp_cnt_q == vlen_q))); // R8
  AST_NO_ISSUE_PAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (iss_cnt_q <= vlen_q)); // R4

endmodule

// File: rtl/vmem_banked.sv
module vmem_banked #(
  parameter int NBANK    = 8,
  parameter int ADDR_W   = 8,
  parameter int LEN_W    = 7,
  parameter int DATA_W   = 32,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic [LEN_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic [LEN_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  output logic              done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;

  // internal events, named for the assertions
  logic [NBANK-1:0] acc_vec, free_vec, fin_vec;
  logic [ROW_W-1:0] acc_row;
  logic [LEN_W-1:0] acc_idx;
  logic             acc_we;
  logic [LEN_W-1:0]  fin_idx  [NBANK];
  logic [DATA_W-1:0] fin_data [NBANK];

  vmem_issue #(.NBANK(NBANK), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .base(base), .stride(stride), .vlen(vlen),
    .bank_free(free_vec), .fin_any(|fin_vec),
    .acc_vec(acc_vec), .acc_row(acc_row), .acc_idx(acc_idx), .acc_we(acc_we),
    .busy(busy), .done(done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vmem_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .LEN_W(LEN_W), .BUSY_CYC(BUSY_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .acc(acc_vec[b]), .acc_we(acc_we), .acc_row(acc_row),
      .acc_wdata(wr_data), .acc_idx(acc_idx),
      .free(free_vec[b]), .fin(fin_vec[b]),
      .fin_idx(fin_idx[b]), .fin_data(fin_data[b])
    );
  end

  // at most one bank finishes per cycle, so an OR-mux is enough
  always_comb begin
    rsp_idx  = '0;
    rsp_data = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (fin_vec[b]) begin
        rsp_idx  = rsp_idx  | fin_idx[b];
        rsp_data = rsp_data | fin_data[b];
      end
    end
  end

  assign rsp_valid = |fin_vec;
  assign wr_idx    = acc_idx;

  AST_ONE_ACCEPT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_vec)); // R4
  AST_ONE_FINISH_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin_vec)); // R6
  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rsp_valid); // R8

endmodule

// File: tb/test_vmem_banked.sv
`timescale 1ns/1ps
module test_vmem_banked;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 7;

  logic              clk = 1'b0;
  logic              rst_n, start, is_write;
  logic [7:0]        base, stride;
  logic [LEN_W-1:0]  vlen, wr_idx, rsp_idx;
  logic [DATA_W-1:0] wr_data, rsp_data;
  logic              busy, rsp_valid, done;

  always #4 clk = ~clk; // 125 MHz

  vmem_banked i_vmem_banked (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .base(base), .stride(stride), .vlen(vlen), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data), .done(done)
  );

  int wseed = 1;
  assign wr_data = DATA_W'(wseed * 256 + int'(wr_idx));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ncheck = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // response monitor
  bit capture = 0;
  int ev_n, done_cyc;
  int ev_cyc [256];
  int ev_idx [256];
  logic [DATA_W-1:0] ev_data [256];
  always @(negedge clk) begin
    if (capture) begin
      if (rsp_valid && ev_n < 256) begin
        ev_cyc[ev_n]  = cyc;
        ev_idx[ev_n]  = int'(rsp_idx);
        ev_data[ev_n] = rsp_data;
        ev_n++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
    end
  end

  logic [DATA_W-1:0] shadow [256];

  // drive one vector and compare against an independent bank-timing model
  task automatic run_vec(input bit we, input int b0, input int st, input int n,
                         input string req, input bit poke);
    int iss_t [128];
    int free_at [8];
    int t, s, addr, bk, exp_done, waitc;
    logic [DATA_W-1:0] expd;
    for (int k = 0; k < 8; k++) free_at[k] = 0;
    t = 1;
    for (int i = 0; i < n; i++) begin
      addr = (b0 + i * st) % 256;
      bk = addr % 8;
      if (free_at[bk] > t) t = free_at[bk];
      iss_t[i] = t;
      free_at[bk] = t + 7;
      t++;
    end
    @(negedge clk);
    ev_n = 0; done_cyc = -1; capture = 1;
    start = 1; is_write = we; base = 8'(b0); stride = 8'(st); vlen = LEN_W'(n);
    s = cyc;
    @(negedge clk);
    start = 0;
    if (poke) begin
      start = 1; is_write = ~we; base = 8'(b0 + 77); stride = 8'd1; vlen = 7'd3;
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (done_cyc < 0 && waitc < 1000) begin
      @(negedge clk);
      waitc++;
    end
    @(negedge clk);
    capture = 0;
    chk(ev_n == n, req, "response count", ev_n, n);
    for (int i = 0; i < n && i < ev_n; i++) begin
      addr = (b0 + i * st) % 256;
      expd = we ? DATA_W'(wseed * 256 + i) : shadow[addr];
      chk(ev_idx[i] == i, req, "response index", ev_idx[i], i);
      chk(ev_cyc[i] == s + iss_t[i] + 6, req, "response cycle", ev_cyc[i] - s, iss_t[i] + 6);
      chk(ev_data[i] == expd, req, "response data", ev_data[i], expd);
    end
    exp_done = (n == 0) ? s + 1 : s + iss_t[n-1] + 7;
    chk(done_cyc == exp_done, req, "done cycle", done_cyc - s, exp_done - s);
    chk(busy == 1'b0, req, "busy after done", busy, 0);
    if (we) for (int i = 0; i < n; i++) shadow[(b0 + i * st) % 256] = DATA_W'(wseed * 256 + i);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; is_write = 0; base = 0; stride = 0; vlen = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rsp_valid == 0 && done == 0, "R1", "outputs in reset",
        {busy, rsp_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && rsp_valid == 0 && done == 0, "R1", "outputs after reset",
        {busy, rsp_valid, done}, 0);
  endtask

  task automatic t_unit_stride();
    wseed = 3;  run_vec(1, 0, 1, 32, "R5_R7_R8", 0);  // unit-stride store, bank 0 reused at element 8
    run_vec(0, 0, 1, 16, "R5_R6", 0);                 // unit-stride load
  endtask

  task automatic t_same_bank();
    run_vec(0, 0, 8, 4, "R3", 0);                     // all in bank 0: seven-cycle spacing
  endtask

  task automatic t_partial_conflict();
    run_vec(0, 0, 2, 8, "R4", 0);                     // four banks: element 4 stalls
  endtask

  task automatic t_odd_stride();
    wseed = 5;  run_vec(1, 5, 3, 20, "R2_R5", 0);     // eight distinct banks, no stall
    run_vec(0, 5, 3, 20, "R2_R6", 0);
  endtask

  task automatic t_wrap();
    wseed = 9;  run_vec(1, 250, 1, 10, "R2_R7", 0);   // crosses address 255
    run_vec(0, 252, 1, 8, "R2", 0);
  endtask

  task automatic t_start_ignored();
    run_vec(0, 0, 2, 12, "R9", 1);                    // start pulse mid-vector ignored
  endtask

  task automatic t_empty();
    run_vec(0, 3, 1, 0, "R10", 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", ncheck, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      ncheck++; nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    t_reset();
    t_unit_stride();
    t_same_bank();
    t_partial_conflict();
    t_odd_stride();
    t_wrap();
    t_start_ignored();
    t_empty();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule